// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer loop. It divides a fast input clock by N = P*B + A and issues one output pulse per N input cycles; that pulse goes to the phase detector. The ratio steps in units of one, so the synthesized output can be placed on a grid equal to the comparison frequency.

Inside, a dual-modulus prescaler counts either P+1 or P input cycles per prescaler cycle. A swallow counter, loaded with A, keeps the prescaler at P+1 until it has run down to zero. A main counter, loaded with B, counts every prescaler cycle and closes the division cycle. The prescaler is synchronous logic on the input clock. New A, B and modulus settings take effect only at the reload boundary that ends a division cycle. A registered status bit flags settings that cannot give the ratio P*B + A.

Top module: `pulse_swallow_divider`

## Requirements
- R1: With a legal setting (B >= 3 and A <= B), `div_out` pulses exactly once every P*B + A clock cycles.
- R2: `psel` picks the modulus pair: 0 gives 8/9, 1 gives 16/17, 2 gives 32/33 and 3 gives 64/65.
- R3: The first A prescaler cycles of a division cycle are P+1 long and the remaining ones are P long. A = 0 gives exactly P*B and A = B gives exactly (P+1)*B.
- R4: The full 11-bit B range and the full 6-bit A range are usable: B = 2047 with A = 63 and P = 8 gives a period of 16439 cycles.
- R5: `div_out` is high for exactly one clock cycle per division cycle.
- R6: `swal_cnt`, `main_cnt` and `psel` are sampled only on the clock edge that ends a division cycle. A change made during a period does not alter that period, and it governs the period that follows.
- R7: `cfg_bad` is 1 exactly when the setting sampled at the last reload had B < 3 or A > B. While it is 1, the period is P*max(B,1) + min(A, max(B,1)).
- R8: While `rst` is high, `div_out` is 0 and the inputs are sampled. The first pulse comes on the N-th rising edge after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock (divided signal) |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 2 | Prescaler modulus select, P = 8 << psel |
| swal_cnt | input | 6 | Swallow value A |
| main_cnt | input | 11 | Main value B |
| div_out | output | 1 | One-cycle pulse per division cycle |
| cfg_bad | output | 1 | Setting in force violates B >= 3 or A <= B |

## Verification
Any wrong value held in the prescaler, swallow or main counter shortens or lengthens the current division cycle. That shows up at the very next `div_out` pulse as an interval different from P*B + A, so the interval between consecutive pulses is compared against a model on every period. A setting latched at the wrong moment shifts which period carries the new ratio, and `cfg_bad` goes wrong together with it. To catch this, settings are changed in the middle of a period and the bench expects the old ratio first and the new ratio one period later. A pulse that stretches over two cycles is visible one cycle after it begins.

// File: rtl/pswd_pkg.sv
package pswd_pkg;
  // Base modulus for exponent e (P = 2**e).
  function automatic logic [31:0] base_of(input int unsigned e);
    return 32'd1 << e;
  endfunction
endpackage

// File: rtl/pswd_prescaler.sv
module pswd_prescaler #(
  parameter int LOG2_MIN = 3,
  parameter int PRE_W    = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] mod_next,
  output logic             term
);
  localparam logic [PRE_W-1:0] MIN_MOD = PRE_W'(1 << LOG2_MIN);

  logic [PRE_W-1:0] cnt;

  assign term = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || term) cnt <= mod_next - PRE_W'(1);
    else             cnt <= cnt - PRE_W'(1);
  end

  AST_MOD_FLOOR: assert property (@(posedge clk) disable iff (rst)
    term |=> (cnt >= MIN_MOD - PRE_W'(1))); // R2
endmodule

// File: rtl/pswd_swallow.sv
module pswd_swallow #(
  parameter int A_W = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [A_W-1:0] a_load,
  output logic           a_nz_next
);
  logic [A_W-1:0] a_left;
  logic [A_W-1:0] a_next;

  always_comb begin
    if (rst || load)             a_next = a_load;
    else if (step && a_left != '0) a_next = a_left - A_W'(1);
    else                         a_next = a_left;
  end

  assign a_nz_next = (a_next != '0);

  always_ff @(posedge clk) a_left <= a_next;

  AST_A_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (a_left == '0 && !load) |=> (a_left == '0)); // R3
endmodule

// File: rtl/pswd_main.sv
module pswd_main #(
  parameter int B_W = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [B_W-1:0] b_load,
  output logic           last
);
  logic [B_W-1:0] b_left;

  assign last = (b_left <= B_W'(1));

  always_ff @(posedge clk) begin
    if (rst || load) b_left <= b_load;
    else if (step)   b_left <= b_left - B_W'(1);
  end

  AST_B_DECR: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (b_left == $past(b_left) - B_W'(1))); // R1
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider #(
  parameter int SEL_W    = 2,
  parameter int LOG2_MIN = 3,
  parameter int A_W      = 6,
  parameter int B_W      = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] psel,
  input  logic [A_W-1:0]   swal_cnt,
  input  logic [B_W-1:0]   main_cnt,
  output logic             div_out,
  output logic             cfg_bad
);
  localparam int PRE_W = LOG2_MIN + (1 << SEL_W);

  logic             term;
  logic             last;
  logic             reload;
  logic             step;
  logic             a_nz_next;
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_use;
  logic [PRE_W-1:0] base_next;
  logic [PRE_W-1:0] mod_next;
  logic             bad_in;

  assign reload  = term && last;
  assign step    = term && !last;
  assign sel_use = (rst || reload) ? psel : sel_q;
  assign base_next = PRE_W'(pswd_pkg::base_of(LOG2_MIN + int'(sel_use)));
  assign mod_next  = base_next + PRE_W'(a_nz_next);
  assign bad_in    = (main_cnt < B_W'(3)) || (B_W'(swal_cnt) > main_cnt);

  pswd_prescaler #(.LOG2_MIN(LOG2_MIN), .PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .mod_next(mod_next), .term(term));

  pswd_swallow #(.A_W(A_W)) u_swal (
    .clk(clk), .rst(rst), .load(reload), .step(step),
    .a_load(swal_cnt), .a_nz_next(a_nz_next));

  pswd_main #(.B_W(B_W)) u_main (
    .clk(clk), .rst(rst), .load(reload), .step(step),
    .b_load(main_cnt), .last(last));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= psel;
      cfg_bad <= bad_in;
      div_out <= 1'b0;
    end else begin
      div_out <= reload;
      if (reload) begin
        sel_q   <= psel;
        cfg_bad <= bad_in;
      end
    end
  end

  AST_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out); // R5
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reload |=> $stable(sel_q)); // R6
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reload |=> $stable(cfg_bad)); // R7
endmodule

// File: tb/test_pulse_swallow_divider.sv
module test_pulse_swallow_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  psel = 2'd0;
  logic [5:0]  swal_cnt = 6'd5;
  logic [10:0] main_cnt = 11'd10;
  logic        div_out;
  logic        cfg_bad;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pulse_swallow_divider i_pulse_swallow_divider (
    .clk(clk), .rst(rst), .psel(psel), .swal_cnt(swal_cnt),
    .main_cnt(main_cnt), .div_out(div_out), .cfg_bad(cfg_bad));

  function automatic int exp_n(int s, int a, int b);
    int p = 8 << s;
    int bb = (b < 1) ? 1 : b;
    return bb * p + ((a < bb) ? a : bb);
  endfunction

  function automatic bit exp_bad(int a, int b);
    return (b < 3) || (a > b);
  endfunction

  task automatic check(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n == 1) check("R5 pulse width", int'(div_out), 0);
      else if (div_out) break;
      if (n > 140000) break;
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 195000);
      summary();
    end
  end

  int cs[$], ca[$], cb[$];

  task automatic add(int s, int a, int b);
    cs.push_back(s); ca.push_back(a); cb.push_back(b);
  endtask

  initial begin
    int n, ps, pa, pb;
    void'($urandom(32'd4242));
    // directed: each modulus (R2), A = 0 and A = B (R3), full range (R4), illegal (R7)
    add(1, 3, 7);  add(2, 0, 4);  add(3, 9, 9);  add(0, 0, 12);
    add(0, 63, 2047); add(0, 0, 2); add(0, 10, 5); add(1, 1, 3);
    for (int i = 0; i < 18; i++) begin
      int b = 3 + int'($urandom % 58);
      int lim = (b < 63) ? b : 63;
      add(int'($urandom % 4), int'($urandom % (lim + 1)), b);
    end

    repeat (3) @(negedge clk);
    check("R8 reset div_out", int'(div_out), 0);
    check("R8 reset flag", int'(cfg_bad), 0);
    @(negedge clk);
    rst = 1'b0;
    wait_pulse(n);
    check("R8 first period", n, exp_n(0, 5, 10));
    check("R7 flag", int'(cfg_bad), 0);
    ps = 0; pa = 5; pb = 10;
    for (int i = 0; i < cs.size(); i++) begin
      psel = 2'(cs[i]); swal_cnt = 6'(ca[i]); main_cnt = 11'(cb[i]);
      wait_pulse(n);
      // R6: inputs changed mid-period, old ratio still applies (R1, R3, R4 values)
      check(exp_bad(pa, pb) ? "R7 period" : "R1 R6 period", n, exp_n(ps, pa, pb));
      check("R7 flag", int'(cfg_bad), int'(exp_bad(ca[i], cb[i])));
      ps = cs[i]; pa = ca[i]; pb = cb[i];
    end
    wait_pulse(n);
    check("R1 R2 final period", n, exp_n(ps, pa, pb));
    summary();
  end
endmodule